// File: doc/BRIEF.md
# Dual-Port Shared Work RAM with Mode-Selected Mapping

Two processors, a main CPU and a secondary CPU, share one work memory made of two equal halves: a low bank and a high bank. Each processor has its own access port and issues byte, halfword or word reads and writes into a shared address window twice the size of one half. An 8-bit control register is written only through the main-side control port. The secondary side reads it back. Its two low bits select one of four mappings. The main side can get the whole store, or the secondary side can get it, or each side can get a different half repeated across its window.

When the mapping gives the secondary port nothing, its accesses are sent to a private memory of its own. That memory is indexed by the low `PRIV_AW` address bits. A port with no mapping reads zero, and its writes change nothing. Accesses are aligned to their size, and read data comes back right-aligned and zero-extended. Both ports run at the same time without stalls.

The defaults give a small instance. Setting `HALF_AW=14` and `PRIV_AW=16` gives two 16 KiB halves, a 32 KiB window and a 64 KiB private memory.

Top module: `wram_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the control register clears to 0x00 and both `*_rvalid` outputs clear to 0. `*_rdata` is 0 whenever `*_rvalid` is 0.
- R2: A `cfg_we` pulse stores all 8 bits of `cfg_wdata`, visible on `cfg_rdata` from the next cycle. The mode is `cfg_rdata[1:0]`. An access made in the same cycle as the write still uses the old mode.
- R3: In mode 0, the main port maps window offset W (0 to 2·HALF−1) linearly onto the store. The low bank holds offsets below HALF and the high bank holds the rest. The secondary port uses the private memory at address `s_addr mod 2^PRIV_AW`.
- R4: In mode 1, the main port sees the high bank at `W mod HALF`, and the secondary port sees the low bank at `W mod HALF`.
- R5: In mode 2, the main port sees the low bank and the secondary port sees the high bank, each at `W mod HALF`.
- R6: In mode 3, the secondary port maps the whole window linearly, with the same layout the main port has in mode 0.
- R7: A main-port read in mode 3 returns 0. A main-port write in mode 3 changes no byte of either bank.
- R8: The size code is 0 for byte, 1 for halfword, and 2 or 3 for word. A halfword clears address bit 0, and a word clears bits 1:0. Bytes are little-endian within a word. Write data is taken from the low bits of `*_wdata`. Read data is right-aligned with the upper bits zero.
- R9: A read accepted at a clock edge sets `*_rvalid` high for exactly the next cycle, with the data on `*_rdata`. A write or an idle cycle gives `*_rvalid` low.
- R10: Both ports may access the store in the same cycle. Each gets the result that the requirements give for it alone, and the two ports never reach the same bank in one cycle.
- R11: Port address bits at and above the window width are ignored, so the window repeats across the whole port address range. For the private memory, the bits at and above `PRIV_AW` are ignored in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req | input | 1 | Main port access request |
| m_we | input | 1 | Main port write (1) or read (0) |
| m_size | input | 2 | Main port access size code |
| m_addr | input | ADDR_W | Main port byte address |
| m_wdata | input | 32 | Main port write data, right-aligned |
| m_rvalid | output | 1 | Main port read data valid |
| m_rdata | output | 32 | Main port read data |
| s_req | input | 1 | Secondary port access request |
| s_we | input | 1 | Secondary port write (1) or read (0) |
| s_size | input | 2 | Secondary port access size code |
| s_addr | input | ADDR_W | Secondary port byte address |
| s_wdata | input | 32 | Secondary port write data, right-aligned |
| s_rvalid | output | 1 | Secondary port read data valid |
| s_rdata | output | 32 | Secondary port read data |
| cfg_we | input | 1 | Control register write strobe (main side) |
| cfg_wdata | input | 8 | Control register write value |
| cfg_rdata | output | 8 | Control register readback (secondary side) |

## Verification
If the mode decode goes wrong, data written through one port turns up at the wrong bank offset. It shows on the first later read that aliases that location, one cycle after that read is issued. A bad lane-enable or lane-extraction path corrupts only some byte positions, so the bench sweeps every byte, halfword and word offset of every window in every mode, and it reads mirrored addresses with high bits set. A stale mode register or a misrouted bank owner shows on the read that straddles a mode change, or on paired accesses issued in the same cycle.

// File: rtl/wram_pkg.sv
package wram_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_HALF     = 2'd1,
    SZ_WORD     = 2'd2,
    SZ_WORD_ALT = 2'd3
  } acc_size_e;

  // byte lane of the access after forced alignment
  function automatic logic [1:0] lane_of(input logic [1:0] a, input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return a;
      SZ_HALF: return {a[1], 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] lanes_en(input logic [1:0] lane, input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return 4'b0001 << lane;
      SZ_HALF: return 4'b0011 << lane;
      default: return 4'b1111;
    endcase
  endfunction

  // replicate right-aligned write data onto every lane it could land on
  function automatic logic [31:0] lane_fill(input logic [31:0] wd, input logic [1:0] sz);
    case (acc_size_e'(sz))
      SZ_BYTE: return {4{wd[7:0]}};
      SZ_HALF: return {2{wd[15:0]}};
      default: return wd;
    endcase
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] q, input logic [1:0] lane,
                                            input logic [1:0] sz);
    logic [31:0] sh;
    sh = q >> {lane, 3'b000};
    case (acc_size_e'(sz))
      SZ_BYTE: return {24'h0, sh[7:0]};
      SZ_HALF: return {16'h0, sh[15:0]};
      default: return q;
    endcase
  endfunction

endpackage

// File: rtl/wram_ram.sv
module wram_ram #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [3:0]       be,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wd,
  output logic [31:0]      q
);
  localparam int DEPTH = 1 << IDX_W;

  logic [3:0][7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      q <= mem[idx];
      if (we) begin
        for (int i = 0; i < 4; i++) begin
          if (be[i]) mem[idx][i] <= wd[8*i +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/wram_map.sv
module wram_map
  import wram_pkg::*;
#(
  parameter bit IS_MAIN = 1'b1,
  parameter int HALF_AW = 6,
  parameter int PRIV_AW = 8
) (
  input  logic               req,
  input  logic [1:0]         mode,
  input  logic [PRIV_AW-1:0] addr,
  input  logic [1:0]         size,
  output logic               sh_hit,
  output logic               sh_bank,
  output logic [HALF_AW-3:0] sh_idx,
  output logic               pv_hit,
  output logic [PRIV_AW-3:0] pv_idx,
  output logic [1:0]         lane,
  output logic [3:0]         be
);
  assign lane   = lane_of(addr[1:0], size);
  assign be     = lanes_en(lane, size);
  assign sh_idx = addr[HALF_AW-1:2];
  assign pv_idx = addr[PRIV_AW-1:2];

  generate
    if (IS_MAIN) begin : g_main
      always_comb begin
        sh_hit  = req;
        sh_bank = addr[HALF_AW];
        pv_hit  = 1'b0;
        case (mode)
          2'b01:   sh_bank = 1'b1;
          2'b10:   sh_bank = 1'b0;
          2'b11:   sh_hit  = 1'b0;
          default: ;
        endcase
      end
    end else begin : g_sec
      always_comb begin
        sh_hit  = req;
        sh_bank = addr[HALF_AW];
        pv_hit  = 1'b0;
        case (mode)
          2'b00: begin
            sh_hit = 1'b0;
            pv_hit = req;
          end
          2'b01:   sh_bank = 1'b0;
          2'b10:   sh_bank = 1'b1;
          default: ;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/wram_arbiter.sv
module wram_arbiter
  import wram_pkg::*;
#(
  parameter int HALF_AW = 6,
  parameter int PRIV_AW = 8,
  parameter int ADDR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m_req,
  input  logic              m_we,
  input  logic [1:0]        m_size,
  input  logic [ADDR_W-1:0] m_addr,
  input  logic [31:0]       m_wdata,
  output logic              m_rvalid,
  output logic [31:0]       m_rdata,
  input  logic              s_req,
  input  logic              s_we,
  input  logic [1:0]        s_size,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [31:0]       s_wdata,
  output logic              s_rvalid,
  output logic [31:0]       s_rdata,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata
);
  localparam int HW = HALF_AW - 2;
  localparam int PW = PRIV_AW - 2;

  logic [7:0] ctl_q;

  logic          m_hit, m_bank, m_pv;
  logic [HW-1:0] m_idx;
  logic [PW-1:0] m_pidx;
  logic [1:0]    m_lane;
  logic [3:0]    m_be;

  logic          s_hit, s_bank, s_pv;
  logic [HW-1:0] s_idx;
  logic [PW-1:0] s_pidx;
  logic [1:0]    s_lane;
  logic [3:0]    s_be;

  wram_map #(.IS_MAIN(1'b1), .HALF_AW(HALF_AW), .PRIV_AW(PRIV_AW)) u_mmap (
    .req(m_req), .mode(ctl_q[1:0]), .addr(m_addr[PRIV_AW-1:0]), .size(m_size),
    .sh_hit(m_hit), .sh_bank(m_bank), .sh_idx(m_idx), .pv_hit(m_pv), .pv_idx(m_pidx),
    .lane(m_lane), .be(m_be)
  );

  wram_map #(.IS_MAIN(1'b0), .HALF_AW(HALF_AW), .PRIV_AW(PRIV_AW)) u_smap (
    .req(s_req), .mode(ctl_q[1:0]), .addr(s_addr[PRIV_AW-1:0]), .size(s_size),
    .sh_hit(s_hit), .sh_bank(s_bank), .sh_idx(s_idx), .pv_hit(s_pv), .pv_idx(s_pidx),
    .lane(s_lane), .be(s_be)
  );

  logic [31:0] bk_q [2];

  // one port per bank: the mode never lets both sides own the same bank
  generate
    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic          own_m, own_s, en, we;
      logic [3:0]    be;
      logic [HW-1:0] idx;
      logic [31:0]   wd;

      assign own_m = m_hit && (m_bank == 1'(b));
      assign own_s = s_hit && (s_bank == 1'(b));
      assign en    = own_m || own_s;

      always_comb begin
        if (own_m) begin
          we  = m_we;
          be  = m_be;
          idx = m_idx;
          wd  = lane_fill(m_wdata, m_size);
        end else begin
          we  = s_we;
          be  = s_be;
          idx = s_idx;
          wd  = lane_fill(s_wdata, s_size);
        end
      end

      wram_ram #(.IDX_W(HW)) u_ram (
        .clk(clk), .en(en), .we(we), .be(be), .idx(idx), .wd(wd), .q(bk_q[b])
      );
    end
  endgenerate

  logic [31:0] pv_q;

  wram_ram #(.IDX_W(PW)) u_priv (
    .clk(clk), .en(s_pv), .we(s_we), .be(s_be), .idx(s_pidx),
    .wd(lane_fill(s_wdata, s_size)), .q(pv_q)
  );

  logic       m_rv, m_rhit, m_rbank;
  logic [1:0] m_rlane, m_rsz;
  logic       s_rv, s_rhit, s_rbank, s_rpv;
  logic [1:0] s_rlane, s_rsz;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= 8'h00;
      m_rv  <= 1'b0;
      s_rv  <= 1'b0;
    end else begin
      if (cfg_we) ctl_q <= cfg_wdata;
      m_rv <= m_req && !m_we;
      s_rv <= s_req && !s_we;
    end
    m_rhit  <= m_hit;
    m_rbank <= m_bank;
    m_rlane <= m_lane;
    m_rsz   <= m_size;
    s_rhit  <= s_hit;
    s_rbank <= s_bank;
    s_rpv   <= s_pv;
    s_rlane <= s_lane;
    s_rsz   <= s_size;
  end

  always_comb begin
    m_rdata = 32'h0;
    if (m_rv && m_rhit) m_rdata = lane_pick(bk_q[m_rbank], m_rlane, m_rsz);
    s_rdata = 32'h0;
    if (s_rv) begin
      if (s_rpv)      s_rdata = lane_pick(pv_q, s_rlane, s_rsz);
      else if (s_rhit) s_rdata = lane_pick(bk_q[s_rbank], s_rlane, s_rsz);
    end
  end

  assign m_rvalid  = m_rv;
  assign s_rvalid  = s_rv;
  assign cfg_rdata = ctl_q;
endmodule

// File: rtl/wram_arbiter_chk.sv
module wram_arbiter_chk (
  input logic        clk,
  input logic        rst,
  input logic        m_req,
  input logic        m_we,
  input logic        m_rvalid,
  input logic [31:0] m_rdata,
  input logic        s_req,
  input logic        s_we,
  input logic [1:0]  s_size,
  input logic [31:0] s_rdata,
  input logic        cfg_we,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic        m_hit,
  input logic        m_bank,
  input logic        s_hit,
  input logic        s_bank
);
  p_rd_valid_r9: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_we) |=> m_rvalid);

  p_no_rd_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !(m_req && !m_we) |=> !m_rvalid);

  p_ctl_store_r2: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == $past(cfg_wdata));

  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> $stable(cfg_rdata));

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_we && cfg_rdata[1:0] == 2'b11) |=> m_rdata == 32'h0);

  p_byte_zext_r8: assert property (@(posedge clk) disable iff (rst)
    (s_req && !s_we && s_size == 2'b00) |=> s_rdata[31:8] == 24'h0);

  p_bank_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(m_hit && s_hit && (m_bank == s_bank)));

  p_sec_private_r3: assert property (@(posedge clk) disable iff (rst)
    (s_req && cfg_rdata[1:0] == 2'b00) |-> !s_hit);
endmodule

bind wram_arbiter wram_arbiter_chk u_chk (.*);

// File: tb/sim_wram_arbiter.sv
module sim_wram_arbiter;
  localparam int CLK_NS  = 10;
  localparam int HALF_AW = 6;
  localparam int PRIV_AW = 8;
  localparam int HALF    = 1 << HALF_AW;
  localparam int WIN     = 2 * HALF;
  localparam int PRIV    = 1 << PRIV_AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_req = 0, m_we = 0, s_req = 0, s_we = 0, cfg_we = 0;
  logic [1:0]  m_size = 0, s_size = 0;
  logic [31:0] m_addr = 0, s_addr = 0, m_wdata = 0, s_wdata = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        m_rvalid, s_rvalid;
  logic [31:0] m_rdata, s_rdata;
  logic [7:0]  cfg_rdata;

  always #(CLK_NS/2) clk = ~clk;

  wram_arbiter #(.HALF_AW(HALF_AW), .PRIV_AW(PRIV_AW), .ADDR_W(32)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  int cur_mode = 0;
  logic [7:0] sh_m [WIN];
  logic [7:0] pv_m [PRIV];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // physical byte index for a port, -1 when unmapped; priv set for the private memory
  function automatic int map_byte(input bit is_main, input int mode, input int a, output bit priv);
    int w, h;
    w = a % WIN;
    h = w % HALF;
    priv = 0;
    if (is_main) begin
      case (mode)
        0: return w;
        1: return HALF + h;
        2: return h;
        default: return -1;
      endcase
    end else begin
      case (mode)
        0: begin priv = 1; return a % PRIV; end
        1: return h;
        2: return HALF + h;
        default: return w;
      endcase
    end
  endfunction

  function automatic int aln(input int a, input int sz);
    if (sz == 0) return a;
    if (sz == 1) return a & ~1;
    return a & ~3;
  endfunction

  function automatic int nbytes(input int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] mread(input bit is_main, input int mode, input int a, input int sz);
    logic [31:0] v = 0;
    for (int i = 0; i < nbytes(sz); i++) begin
      bit p;
      int idx = map_byte(is_main, mode, aln(a, sz) + i, p);
      if (idx >= 0) v[8*i +: 8] = p ? pv_m[idx] : sh_m[idx];
    end
    return v;
  endfunction

  task automatic mwrite(input bit is_main, input int mode, input int a, input int sz, input logic [31:0] d);
    for (int i = 0; i < nbytes(sz); i++) begin
      bit p;
      int idx = map_byte(is_main, mode, aln(a, sz) + i, p);
      if (idx >= 0) begin
        if (p) pv_m[idx] = d[8*i +: 8];
        else   sh_m[idx] = d[8*i +: 8];
      end
    end
  endtask

  function automatic string tag_of(input bit is_main, input int mode, input int sz);
    string t;
    if (is_main && mode == 3) t = "R7";
    else begin
      case (mode)
        0: t = "R3";
        1: t = "R4";
        2: t = "R5";
        default: t = "R6";
      endcase
    end
    if (sz != 2) t = {t, "/R8"};
    return $sformatf("%s %s", is_main ? "main" : "sec", t);
  endfunction

  task automatic step(input bit mr, input bit mw, input int ms, input int ma, input logic [31:0] md,
                      input bit sr, input bit sw, input int ss, input int sa, input logic [31:0] sd,
                      input bit cw, input logic [7:0] cd, input string tag);
    logic [31:0] em, es;
    em = (mr && !mw) ? mread(1, cur_mode, ma, ms) : 32'h0;
    es = (sr && !sw) ? mread(0, cur_mode, sa, ss) : 32'h0;
    if (sr && sw) mwrite(0, cur_mode, sa, ss, sd);
    if (mr && mw) mwrite(1, cur_mode, ma, ms, md);
    if (cw) cur_mode = int'(cd[1:0]);
    m_req = mr; m_we = mw; m_size = 2'(ms); m_addr = ma; m_wdata = md;
    s_req = sr; s_we = sw; s_size = 2'(ss); s_addr = sa; s_wdata = sd;
    cfg_we = cw; cfg_wdata = cd;
    @(posedge clk);
    @(negedge clk);
    m_req = 0; s_req = 0; cfg_we = 0;
    if (mr) begin
      chk({tag, " R9 main valid"}, 32'(m_rvalid), 32'(!mw));
      if (!mw) chk(tag, m_rdata, em);
    end
    if (sr) begin
      chk({tag, " R9 sec valid"}, 32'(s_rvalid), 32'(!sw));
      if (!sw) chk(tag, s_rdata, es);
    end
    if (cw) chk("R2 readback", 32'(cfg_rdata), 32'(cd));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 m_rvalid", 32'(m_rvalid), 0);
    chk("R1 s_rvalid", 32'(s_rvalid), 0);
    chk("R1 m_rdata", m_rdata, 0);
    chk("R1 s_rdata", s_rdata, 0);
    chk("R1 cfg_rdata", 32'(cfg_rdata), 0);
    rst = 0;

    // fill the store and the private memory through high-bit aliases (R11)
    for (int w = 0; w < WIN / 4; w++)
      step(1, 1, 2, w * 4 + WIN * (w % 3), 32'hA500_0000 ^ (w * 32'h0101_0103),
           0, 0, 0, 0, 0, 0, 0, "R11 init");
    for (int p = 0; p < PRIV / 4; p++)
      step(0, 0, 0, 0, 0, 1, 1, 2, p * 4 + PRIV * (p % 2), 32'h5A00_0000 ^ (p * 32'h0301_0207),
           0, 0, "R11 init");

    for (int mode = 0; mode < 4; mode++) begin
      // the read issued with the control write still uses the previous mode
      step(1, 0, 2, 8, 0, 1, 0, 2, 12, 0, 1, 8'hA4 | 8'(mode), "R2 old mode");

      for (int port = 0; port < 2; port++) begin
        for (int k = 0; k < 24; k++) begin
          logic [31:0] d = 32'h1357_9BDF ^ (k * 32'h0102_0305) ^ (mode << 28) ^ (port << 24);
          int a = (k * 11 + 3) % WIN;
          if (port == 0) step(1, 1, k % 3, a, d, 0, 0, 0, 0, 0, 0, 0, "write");
          else           step(0, 0, 0, 0, 0, 1, 1, k % 3, a, d, 0, 0, "write");
        end
      end

      for (int port = 0; port < 2; port++) begin
        int span = (port == 1 && mode == 0) ? PRIV : WIN;
        for (int a = 0; a < span; a++) begin
          for (int sz = 0; sz < 4; sz++) begin
            int ad = a + ((a % 2) ? span * 5 : 0);
            string t = tag_of(port == 0, mode, (sz == 3) ? 2 : sz);
            if (a % 2) t = {t, " R11"};
            if (port == 0) step(1, 0, sz, ad, 0, 0, 0, 0, 0, 0, 0, 0, t);
            else           step(0, 0, 0, 0, 0, 1, 0, sz, ad, 0, 0, 0, t);
          end
        end
      end

      // both ports in the same cycle
      for (int k = 0; k < 16; k++) begin
        step(1, 1, 2, k * 4, 32'hC0DE_0000 + k, 1, 0, 1, k * 4 + 2, 0, 0, 0, "R10 mw/sr");
        step(1, 0, 2, k * 4, 0, 1, 1, 0, k * 4 + 1, 32'h0000_0077 + k, 0, 0, "R10 mr/sw");
        step(1, 0, 0, k * 4 + 3, 0, 1, 0, 2, k * 4, 0, 0, 0, "R10 mr/sr");
      end
    end

    // unmapped main writes in mode 3 leave the banks untouched (R7)
    for (int k = 0; k < 8; k++)
      step(1, 1, 2, k * 8, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0, "R7 discard");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00, "R2 back to 0");
    for (int k = 0; k < 8; k++)
      step(1, 0, 2, k * 8, 0, 0, 0, 0, 0, 0, 0, 0, "R7 discard readback");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule